// File: doc/BRIEF.md
# Field I/O Port with Polarity-Split Edge Interrupts

This block drives and samples a 16-pin general-purpose port for a host that talks to it through seven 16-bit registers on a simple synchronous read/write bus. The host sets the output direction separately for the low byte and the high byte of pins. It writes output data and reads back the synchronized pin levels.

Every pin has two event detectors, one for rising transitions and one for falling transitions. Each detector has its own per-bit enable mask and its own sticky status register, which the host clears by writing ones. The control register reports three summary flags for each byte-half of pins: a falling interrupt is pending, a rising interrupt is pending, or any interrupt is pending. A single level interrupt line is raised while any enabled status bit is set.

A build-time parameter selects what register 1 holds. In the default variant it is the output data register. In the other variant it holds the differential-mode control instead: two bits mark each byte-half as four differential pairs, and six bits give the direction of each pair. In that variant the data outputs are held low.

Top module: `fio_edge_regset`

## Requirements
- R1: After reset, every register reads 0, all pins are inputs (`pin_oe` = 0), `pin_out` is 0 and `irq` is 0.
- R2: Register 0 (control) stores the direction of pins 0-7 in bit 0 and the direction of pins 8-15 in bit 8, where 1 means output. Each of these bits drives the `pin_oe` of its whole byte-half. Bits 1-4 and 9-12 always read 0.
- R3: In the default variant, register 1 holds the output data. It drives `pin_out` and reads back as written.
- R4: Register 2 returns the pin levels after a two-flop synchronizer, so a pin change shows on the second rising clock edge. A byte-half whose direction is output reads as 0.
- R5: A rising transition of a synchronized pin sets its bit in register 3 only when the same bit of register 4 is 1.
- R6: A falling transition of a synchronized pin sets its bit in register 5 only when the same bit of register 6 is 1.
- R7: Writing register 3 or register 5 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R8: If a new enabled edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: Control bits 5, 6 and 7 flag an enabled pending falling event, an enabled pending rising event, and either one, for pins 0-7. Bits 13, 14 and 15 give the same three flags for pins 8-15.
- R10: `irq` is 1 exactly when some status bit is set while its enable bit is also set. Clearing an enable masks the interrupt but keeps the status bit.
- R11: In the differential variant, register 1 bits 0-5 drive `pair_dir` and bits 6 and 7 drive `diff_half` (low half, high half). Bits 8-15 read 0, and `pin_out` stays 0.
- R12: Address 7 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, committed on the rising edge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pin_in | input | 16 | Pin levels from the pads (asynchronous) |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Per-pin output enable |
| diff_half | output | 2 | Differential-mode flag per byte-half |
| pair_dir | output | 6 | Direction of each differential pair |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these properties:
- a control write moves the two direction enables;
- the reserved control bits and the read data of an output half stay at zero;
- no status bit appears without its enable;
- a write-one-to-clear removes only the unrenewed bits while a fresh edge survives;
- `irq` never rises with both status registers empty.

Only the bench scenarios show the rest:
- the exact synchronizer latency;
- the mapping of each summary flag to its half and polarity;
- the masking of `irq` with the status kept;
- the read-back of both register-1 variants;
- the inertness of address 7.

// File: rtl/fio_edge_regset.sv
module fio_edge_regset #(
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit DIFF_VARIANT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic [1:0]    diff_half,
  output logic [5:0]    pair_dir,
  output logic          irq
);
  localparam int HW = DW / 2;

  logic [SYNC_STAGES-1:0][DW-1:0] sync_q;
  logic [DW-1:0] prev_q, pin_s, rise_evt, fall_evt;
  logic [DW-1:0] rise_st, rise_en, fall_st, fall_en;
  logic [DW-1:0] reg1_rd, ctl_rd, rise_pend, fall_pend;
  logic dir_l, dir_h;

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign rise_evt = pin_s & ~prev_q;
  assign fall_evt = ~pin_s & prev_q;

  wire wr_ctl = wr_en && addr == 3'd0;
  wire wr_rs  = wr_en && addr == 3'd3;
  wire wr_re  = wr_en && addr == 3'd4;
  wire wr_fs  = wr_en && addr == 3'd5;
  wire wr_fe  = wr_en && addr == 3'd6;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= '0;
      dir_l   <= 1'b0;
      dir_h   <= 1'b0;
      rise_st <= '0;
      rise_en <= '0;
      fall_st <= '0;
      fall_en <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q  <= pin_s;
      if (wr_ctl) begin
        dir_l <= wdata[0];
        dir_h <= wdata[HW];
      end
      if (wr_re) rise_en <= wdata;
      if (wr_fe) fall_en <= wdata;
      rise_st <= (rise_st & ~(wr_rs ? wdata : '0)) | (rise_evt & rise_en);
      fall_st <= (fall_st & ~(wr_fs ? wdata : '0)) | (fall_evt & fall_en);
    end
  end

  generate
    if (DIFF_VARIANT) begin : g_diff
      logic [7:0] dd_q;
      always_ff @(posedge clk) begin
        if (!rst_n) dd_q <= '0;
        else if (wr_en && addr == 3'd1) dd_q <= wdata[7:0];
      end
      assign pin_out   = '0;
      assign diff_half = dd_q[7:6];
      assign pair_dir  = dd_q[5:0];
      assign reg1_rd   = {{(DW-8){1'b0}}, dd_q};
    end else begin : g_data
      logic [DW-1:0] out_q;
      always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else if (wr_en && addr == 3'd1) out_q <= wdata;
      end
      assign pin_out   = out_q;
      assign diff_half = 2'b00;
      assign pair_dir  = 6'b000000;
      assign reg1_rd   = out_q;
    end
  endgenerate

  assign pin_oe    = {{HW{dir_h}}, {HW{dir_l}}};
  assign rise_pend = rise_st & rise_en;
  assign fall_pend = fall_st & fall_en;
  assign irq       = |(rise_pend | fall_pend);

  wire fl = |fall_pend[HW-1:0];
  wire rl = |rise_pend[HW-1:0];
  wire fh = |fall_pend[DW-1:HW];
  wire rh = |rise_pend[DW-1:HW];

  assign ctl_rd = {fh | rh, rh, fh, {(HW-4){1'b0}}, dir_h,
                   fl | rl, rl, fl, {(HW-4){1'b0}}, dir_l};

  always_comb begin
    case (addr)
      3'd0:    rdata = ctl_rd;
      3'd1:    rdata = reg1_rd;
      3'd2:    rdata = pin_s & ~pin_oe;
      3'd3:    rdata = rise_st;
      3'd4:    rdata = rise_en;
      3'd5:    rdata = fall_st;
      3'd6:    rdata = fall_en;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/fio_edge_regset_chk.sv
module fio_edge_regset_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic [15:0] pin_oe,
  input logic        irq,
  input logic [15:0] rise_st,
  input logic [15:0] rise_en,
  input logic [15:0] fall_st,
  input logic [15:0] fall_en,
  input logic [15:0] rise_evt,
  input logic [15:0] fall_evt
);
  AST_DIR_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (pin_oe[0] == $past(wdata[0]) && pin_oe[8] == $past(wdata[8]))); // R2
  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd0) |-> (rdata[4:1] == 4'd0 && rdata[12:9] == 4'd0)); // R2
  AST_OUT_HALF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd2 && pin_oe[0]) |-> rdata[7:0] == 8'd0); // R4
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rise_st & ~$past(rise_st) & ~$past(rise_en)) == 16'd0); // R5
  AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fall_st & ~$past(fall_st) & ~$past(fall_en)) == 16'd0); // R6
  AST_W1C_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> (rise_st & $past(wdata) & ~$past(rise_evt & rise_en)) == 16'd0); // R7
  AST_W1C_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> (fall_st & $past(wdata) & ~$past(fall_evt & fall_en)) == 16'd0); // R7
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_evt & rise_en) != 16'd0) |=> (rise_st & $past(rise_evt & rise_en)) == $past(rise_evt & rise_en)); // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rise_st != 16'd0 || fall_st != 16'd0)); // R10
endmodule

bind fio_edge_regset fio_edge_regset_chk chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pin_oe(pin_oe), .irq(irq),
  .rise_st(rise_st), .rise_en(rise_en), .fall_st(fall_st), .fall_en(fall_en),
  .rise_evt(rise_evt), .fall_evt(fall_evt)
);

// File: tb/fio_edge_regset_test.sv
`timescale 1ns/1ps
module fio_edge_regset_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, pin_in = '0;
  logic [15:0] rdata, pin_out, pin_oe, rdata_d, pin_out_d, pin_oe_d;
  logic [1:0] diff_half, diff_half_d;
  logic [5:0] pair_dir, pair_dir_d;
  logic irq, irq_d;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fio_edge_regset uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .diff_half(diff_half), .pair_dir(pair_dir), .irq(irq));

  fio_edge_regset #(.DIFF_VARIANT(1'b1)) uut_dd (.clk(clk), .rst_n(rst_n), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata_d), .pin_in(pin_in), .pin_out(pin_out_d),
    .pin_oe(pin_oe_d), .diff_half(diff_half_d), .pair_dir(pair_dir_d), .irq(irq_d));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic clocks(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg read after reset", v, 16'h0000);
    end
    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 pin_out", pin_out, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_dir();
    logic [15:0] v;
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v);
    check("R2 control readback reserved zero", v, 16'h0101);
    check("R2 both halves output", pin_oe, 16'hFFFF);
    wr(3'd0, 16'h0001);
    check("R2 low half output only", pin_oe, 16'h00FF);
  endtask

  task automatic t_reg1();
    logic [15:0] v;
    wr(3'd1, 16'hA5C3);
    rd(3'd1, v);
    check("R3 data readback", v, 16'hA5C3);
    check("R3 pin_out", pin_out, 16'hA5C3);
    check("R11 diff readback", rdata_d, 16'h00C3);
    check("R11 diff pin_out low", pin_out_d, 16'h0000);
    check("R11 diff_half", {14'd0, diff_half_d}, 16'h0003);
    check("R11 pair_dir", {10'd0, pair_dir_d}, 16'h0003);
    wr(3'd1, 16'h0040);
    check("R11 diff_half low only", {14'd0, diff_half_d}, 16'h0001);
    check("R11 pair_dir cleared", {10'd0, pair_dir_d}, 16'h0000);
  endtask

  task automatic t_read_pins();
    logic [15:0] v;
    @(negedge clk); pin_in = 16'h3C5A;
    @(posedge clk);
    rd(3'd2, v);
    check("R4 not yet through synchronizer", v, 16'h0000);
    @(posedge clk);
    rd(3'd2, v);
    check("R4 low half output reads zero", v, 16'h3C00);
    wr(3'd0, 16'h0000);
    rd(3'd2, v);
    check("R4 both halves input", v, 16'h3C5A);
  endtask

  task automatic t_rise();
    logic [15:0] v;
    @(negedge clk); pin_in = 16'h0000;
    clocks(4);
    wr(3'd3, 16'hFFFF);
    wr(3'd5, 16'hFFFF);
    wr(3'd4, 16'h00F0);
    @(negedge clk); pin_in = 16'h00FF;
    clocks(4);
    rd(3'd3, v);
    check("R5 rising status only enabled bits", v, 16'h00F0);
    rd(3'd5, v);
    check("R6 no falling status on rise", v, 16'h0000);
    check("R10 irq set", {15'd0, irq}, 16'h0001);
    rd(3'd0, v);
    check("R9 low rising and any flags", v, 16'h00C0);
  endtask

  task automatic t_fall();
    logic [15:0] v;
    wr(3'd6, 16'h0F00);
    @(negedge clk); pin_in = 16'h0000; clocks(4);
    @(negedge clk); pin_in = 16'h0F00; clocks(4);
    @(negedge clk); pin_in = 16'h0000; clocks(4);
    rd(3'd5, v);
    check("R6 falling status only enabled bits", v, 16'h0F00);
    rd(3'd3, v);
    check("R5 unenabled rises ignored", v, 16'h00F0);
    rd(3'd0, v);
    check("R9 high falling flags", v, 16'hA0C0);
  endtask

  task automatic t_w1c_mask();
    logic [15:0] v;
    wr(3'd3, 16'h0030);
    rd(3'd3, v);
    check("R7 partial clear rising", v, 16'h00C0);
    wr(3'd5, 16'h0000);
    rd(3'd5, v);
    check("R7 zero write keeps falling", v, 16'h0F00);
    wr(3'd4, 16'h0000);
    wr(3'd6, 16'h0000);
    check("R10 irq masked", {15'd0, irq}, 16'h0000);
    rd(3'd3, v);
    check("R10 status kept when masked", v, 16'h00C0);
    rd(3'd0, v);
    check("R9 flags follow enables", v, 16'h0000);
    wr(3'd3, 16'h00C0);
    wr(3'd5, 16'h0F00);
    rd(3'd3, v);
    check("R7 rising cleared", v, 16'h0000);
    rd(3'd5, v);
    check("R7 falling cleared", v, 16'h0000);
  endtask

  task automatic t_edge_wins();
    logic [15:0] v;
    wr(3'd4, 16'h0001);
    @(negedge clk); pin_in = 16'h0001; clocks(4);
    @(negedge clk); pin_in = 16'h0000; clocks(4);
    rd(3'd3, v);
    check("R8 setup status set", v, 16'h0001);
    @(negedge clk); pin_in = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); addr = 3'd3; wdata = 16'h0001; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    rd(3'd3, v);
    check("R8 edge beats clear", v, 16'h0001);
    wr(3'd3, 16'h0001);
    rd(3'd3, v);
    check("R7 clear without edge", v, 16'h0000);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr(3'd7, 16'hFFFF);
    rd(3'd7, v);
    check("R12 address 7 reads zero", v, 16'h0000);
    rd(3'd0, v);
    check("R12 control unchanged", v, 16'h0000);
    rd(3'd1, v);
    check("R12 data unchanged", v, 16'h0040);
    rd(3'd4, v);
    check("R12 rise enable unchanged", v, 16'h0001);
    rd(3'd6, v);
    check("R12 fall enable unchanged", v, 16'h0000);
  endtask

  initial begin
    clocks(4);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_dir();
    t_reg1();
    t_read_pins();
    t_rise();
    t_fall();
    t_w1c_mask();
    t_edge_wins();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule